// File: doc/BRIEF.md
# Patchable Microcode Control Store

This block supplies one control word per clock to a microsequencer. Each word comes from one of three places: a read-only microcode array, a small writable patch RAM, or an optional writable control store. The read-only array sits outside the block and is reached through a combinational address/data pair. A memory holding one flag bit per microaddress decides, on every fetch, whether the read-only word or the matching patch RAM word is delivered. This lets boot software replace faulty microwords without touching the read-only contents.

Boot software loads the block through a single write port. The port selects the patch RAM, the flag memory or the writable region, and the patch mechanism is switched on with a global enable afterwards. Each delivered word carries parity, and the parity is checked as the word is registered. The first mismatch sets an error output that stays set until reset. Read-only word 0x17FD is stored with deliberately wrong parity so that the checker can be exercised.

Top module: `ucs_top`

## Requirements
- R1: While reset is high, the output word is all zeros and the parity error output is 0. Reset sets every flag bit to 1, so after reset every address below 0x2000 is served from the read-only array.
- R2: The word for the microaddress presented before a rising edge appears on the output just after that edge, with one register of latency.
- R3: When the patch enable is 1 and the flag bit for an address below 0x2000 is 0, the output is the patch RAM word selected by the address's low 10 bits.
- R4: When the flag bit for an address below 0x2000 is 1, the output is the read-only word for that address.
- R5: When the patch enable is 0, every address below 0x2000 is served from the read-only path, whatever the flag bits hold.
- R6: A read-only-path fetch at an address from the read-only depth (6144) up to 0x1FFF delivers an all-zero word.
- R7: Addresses from 0x2000 up to 0x2000 plus the writable depth (1024) deliver the writable word at the offset from 0x2000. Flag bits do not affect them. Addresses above that range deliver zero.
- R8: Bits 77:0 of a word are payload. Bit 78 is stored as the XOR of bits 38:0, and bit 79 as the XOR of bits 77:39. If a delivered word breaks either rule, the parity error output is 1 on the same edge the word appears.
- R9: Once set, the parity error output stays 1 until reset, whatever is fetched.
- R10: A load write occurs at the edge where the load valid is 1. Select code 0 writes the patch RAM at address bits 9:0. Code 1 writes data bit 0 into the flag of address bits 12:0. Code 2 writes the writable region at the address offset from 0x2000. Code 3 writes nothing. A fetch in the same cycle as the write returns the old word, and the new word is seen from the next fetch on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uaddr | input | 14 | Microaddress of the current fetch |
| patch_en | input | 1 | Global patch enable; 0 forces the read-only path |
| ld_valid | input | 1 | Load write strobe |
| ld_sel | input | 2 | Load target: 0 patch RAM, 1 flag bit, 2 writable region, 3 none |
| ld_addr | input | 14 | Load address |
| ld_data | input | 80 | Load data (flag writes use bit 0) |
| rom_addr | output | 13 | Address to the external read-only array |
| rom_data | input | 80 | Combinational word from the read-only array |
| cw | output | 80 | Registered control word |
| par_err | output | 1 | Sticky control-store parity error |

## Verification
The hardest situation to reach is the mix of patched and unpatched addresses across the whole flag space, with the deliberately bad read-only word sitting behind a patch. The bench clears the flag of every third address from 0 to 0x1FFF, which covers 0x17FD, and fills the whole patch RAM. It then sweeps every address and checks that the bad word stays hidden and the error output stays clear. After that it turns patching off so that 0x17FD reaches the checker, and confirms that the error output sticks through later good fetches. A write made in the same cycle as a fetch of the same patch word is used to pin down read-before-write ordering.

// File: rtl/ucs_pkg.sv
package ucs_pkg;

    localparam int CW_W    = 80;
    localparam int PAR_W   = 2;
    localparam int PAY_W   = CW_W - PAR_W;
    localparam int SLICE_W = PAY_W / PAR_W;
    localparam int UA_W    = 14;

    typedef logic [CW_W-1:0] cword_t;

    typedef enum logic [1:0] {
        LD_PATCH = 2'd0,
        LD_FLAG  = 2'd1,
        LD_WCS   = 2'd2,
        LD_NONE  = 2'd3
    } ld_sel_e;

    typedef enum logic [1:0] {
        SRC_ZERO  = 2'd0,
        SRC_ROM   = 2'd1,
        SRC_PATCH = 2'd2,
        SRC_WCS   = 2'd3
    } src_e;

    // Parity expected for the payload of a word, one bit per payload slice.
    function automatic logic [PAR_W-1:0] par_calc(input cword_t w);
        logic [PAR_W-1:0] p;
        for (int i = 0; i < PAR_W; i++) begin
            p[i] = ^w[i*SLICE_W +: SLICE_W];
        end
        return p;
    endfunction

    function automatic logic par_ok(input cword_t w);
        return w[CW_W-1 -: PAR_W] == par_calc(w);
    endfunction

endpackage

// File: rtl/ucs_flag_mem.sv
module ucs_flag_mem #(
    parameter int DEPTH = 8192,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic          wbit,
    input  logic [AW-1:0] raddr,
    output logic          rbit
);
    logic [DEPTH-1:0] bits_q;

    // Reset selects the read-only source everywhere.
    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q <= '1;
        end else if (we) begin
            bits_q[waddr] <= wbit;
        end
    end

    assign rbit = bits_q[raddr];
endmodule

// File: rtl/ucs_word_ram.sv
module ucs_word_ram
    import ucs_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  cword_t        wdata,
    input  logic [AW-1:0] raddr,
    output cword_t        rdata
);
    cword_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Combinational read: a same-cycle write is seen from the next fetch.
    assign rdata = mem[raddr];
endmodule

// File: rtl/ucs_top.sv
module ucs_top
    import ucs_pkg::*;
#(
    parameter int              ROM_WORDS   = 6144,
    parameter int              FLAG_DEPTH  = 8192,
    parameter int              PATCH_WORDS = 1024,
    parameter logic [UA_W-1:0] WCS_BASE    = 14'h2000,
    parameter int              WCS_WORDS   = 1024,
    localparam int FLAG_AW  = $clog2(FLAG_DEPTH),
    localparam int PATCH_AW = $clog2(PATCH_WORDS),
    localparam int WCS_AW   = (WCS_WORDS > 1) ? $clog2(WCS_WORDS) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [UA_W-1:0]    uaddr,
    input  logic               patch_en,
    input  logic               ld_valid,
    input  logic [1:0]         ld_sel,
    input  logic [UA_W-1:0]    ld_addr,
    input  logic [CW_W-1:0]    ld_data,
    output logic [FLAG_AW-1:0] rom_addr,
    input  logic [CW_W-1:0]    rom_data,
    output logic [CW_W-1:0]    cw,
    output logic               par_err
);
    localparam logic [UA_W-1:0] ROM_END = UA_W'(ROM_WORDS);
    localparam logic [UA_W-1:0] WCS_CNT = UA_W'(WCS_WORDS);

    ld_sel_e         sel;
    logic            in_wcs, ld_in_wcs;
    logic [UA_W-1:0] wcs_off, ld_off;
    logic            flag_bit;
    cword_t          patch_rdata, wcs_rdata, next_cw;
    src_e            src;
    logic            patch_we, flag_we, wcs_we;

    assign sel       = ld_ld_cast(ld_sel);
    assign in_wcs    = uaddr >= WCS_BASE;
    assign wcs_off   = uaddr - WCS_BASE;
    assign ld_in_wcs = ld_addr >= WCS_BASE;
    assign ld_off    = ld_addr - WCS_BASE;

    assign patch_we = ld_valid && sel == LD_PATCH && !ld_in_wcs;
    assign flag_we  = ld_valid && sel == LD_FLAG  && !ld_in_wcs;
    assign wcs_we   = ld_valid && sel == LD_WCS   && ld_in_wcs && ld_off < WCS_CNT;

    function automatic ld_sel_e ld_ld_cast(input logic [1:0] v);
        return ld_sel_e'(v);
    endfunction

    assign rom_addr = uaddr[FLAG_AW-1:0];

    ucs_flag_mem #(.DEPTH(FLAG_DEPTH)) u_flags (
        .clk   (clk),
        .rst   (rst),
        .we    (flag_we),
        .waddr (ld_addr[FLAG_AW-1:0]),
        .wbit  (ld_data[0]),
        .raddr (uaddr[FLAG_AW-1:0]),
        .rbit  (flag_bit)
    );

    ucs_word_ram #(.DEPTH(PATCH_WORDS)) u_patch (
        .clk   (clk),
        .we    (patch_we),
        .waddr (ld_addr[PATCH_AW-1:0]),
        .wdata (ld_data),
        .raddr (uaddr[PATCH_AW-1:0]),
        .rdata (patch_rdata)
    );

    generate
        if (WCS_WORDS > 0) begin : g_wcs
            ucs_word_ram #(.DEPTH(WCS_WORDS)) u_wcs (
                .clk   (clk),
                .we    (wcs_we),
                .waddr (ld_off[WCS_AW-1:0]),
                .wdata (ld_data),
                .raddr (wcs_off[WCS_AW-1:0]),
                .rdata (wcs_rdata)
            );
        end else begin : g_no_wcs
            assign wcs_rdata = '0;
        end
    endgenerate

    // Source choice for this fetch.
    always_comb begin
        src = SRC_ZERO;
        if (in_wcs) begin
            if (WCS_WORDS > 0 && wcs_off < WCS_CNT) src = SRC_WCS;
        end else if (!patch_en || flag_bit) begin
            if (uaddr < ROM_END) src = SRC_ROM;
        end else begin
            src = SRC_PATCH;
        end
    end

    always_comb begin
        unique case (src)
            SRC_ROM:   next_cw = rom_data;
            SRC_PATCH: next_cw = patch_rdata;
            SRC_WCS:   next_cw = wcs_rdata;
            default:   next_cw = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cw      <= '0;
            par_err <= 1'b0;
        end else begin
            cw      <= next_cw;
            par_err <= par_err | !par_ok(next_cw);
        end
    end
endmodule

// File: rtl/ucs_top_chk.sv
module ucs_top_chk
    import ucs_pkg::*;
#(
    parameter int              ROM_WORDS  = 6144,
    parameter logic [UA_W-1:0] WCS_BASE   = 14'h2000,
    parameter int              WCS_WORDS  = 1024,
    parameter int              FLAG_DEPTH = 8192,
    localparam int FLAG_AW = $clog2(FLAG_DEPTH)
) (
    input logic               clk,
    input logic               rst,
    input logic [UA_W-1:0]    uaddr,
    input logic               patch_en,
    input logic [FLAG_AW-1:0] rom_addr,
    input logic [CW_W-1:0]    rom_data,
    input logic [CW_W-1:0]    cw,
    input logic               par_err
);
    localparam int WCS_END = int'(WCS_BASE) + WCS_WORDS;

    // R9: error flag is sticky
    p_sticky_err_r9: assert property (@(posedge clk) disable iff (rst)
        par_err |=> par_err);

    // R8: a delivered word with bad parity is always flagged
    p_bad_word_flagged_r8: assert property (@(posedge clk) disable iff (rst)
        !par_ok(cw) |-> par_err);

    // R5: with patching off, in-range addresses return the read-only word
    p_rom_when_off_r5: assert property (@(posedge clk) disable iff (rst)
        (!patch_en && int'(uaddr) < ROM_WORDS) |=> cw == $past(rom_data));

    // R6: hole between the read-only depth and the writable base reads zero
    p_rom_hole_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (!patch_en && int'(uaddr) >= ROM_WORDS && uaddr < WCS_BASE) |=> cw == '0);

    // R7: above the writable region the word is zero
    p_wcs_beyond_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (int'(uaddr) >= WCS_END) |=> cw == '0);
endmodule

bind ucs_top ucs_top_chk #(
    .ROM_WORDS  (ROM_WORDS),
    .WCS_BASE   (WCS_BASE),
    .WCS_WORDS  (WCS_WORDS),
    .FLAG_DEPTH (FLAG_DEPTH)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .uaddr    (uaddr),
    .patch_en (patch_en),
    .rom_addr (rom_addr),
    .rom_data (rom_data),
    .cw       (cw),
    .par_err  (par_err)
);

// File: tb/ucs_top_tb.sv
module ucs_top_tb;
    import ucs_pkg::*;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [13:0]     uaddr = '0;
    logic            patch_en = 1'b1;
    logic            ld_valid = 1'b0;
    logic [1:0]      ld_sel = 2'd3;
    logic [13:0]     ld_addr = '0;
    logic [79:0]     ld_data = '0;
    logic [12:0]     rom_addr;
    logic [79:0]     rom_data;
    logic [79:0]     cw;
    logic            par_err;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #4 clk = ~clk;

    function automatic logic [79:0] mk(input logic [77:0] pay);
        return {^pay[77:39], ^pay[38:0], pay};
    endfunction

    function automatic logic [79:0] rom_fn(input logic [12:0] a);
        logic [63:0] a64;
        logic [79:0] w;
        a64 = 64'(a);
        w = mk({a, 26'((a64 * 64'h9E3779B1) >> 3), 39'(a64 * 64'h5DEECE66D)});
        if (a == 13'h17FD) w[79] = ~w[79];
        return w;
    endfunction

    function automatic logic [79:0] pat_fn(input int i);
        return mk(78'(64'(i) * 64'hC2B2AE3D27D4EB4F) ^ {10'(i), 68'h0});
    endfunction

    function automatic logic [79:0] wcs_fn(input int i);
        return mk(~78'(64'(i) * 64'h165667B19E3779F9));
    endfunction

    assign rom_data = rom_fn(rom_addr);

    ucs_top u_dut (
        .clk      (clk),
        .rst      (rst),
        .uaddr    (uaddr),
        .patch_en (patch_en),
        .ld_valid (ld_valid),
        .ld_sel   (ld_sel),
        .ld_addr  (ld_addr),
        .ld_data  (ld_data),
        .rom_addr (rom_addr),
        .rom_data (rom_data),
        .cw       (cw),
        .par_err  (par_err)
    );

    task automatic chk(input string req, input logic [79:0] got, input logic [79:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic load(input logic [1:0] s, input int a, input logic [79:0] d);
        @(negedge clk);
        ld_valid = 1'b1; ld_sel = s; ld_addr = 14'(a); ld_data = d;
        @(posedge clk);
        #1 ld_valid = 1'b0;
    endtask

    task automatic fetch(input int a);
        @(negedge clk);
        uaddr = 14'(a);
        @(posedge clk);
        #1;
    endtask

    initial begin
        while (cycles < 200000) begin
            @(posedge clk);
            cycles++;
        end
        n_tests++; n_fail++;
        $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [79:0] old6;
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset cw", cw, '0);
        chk("R1 reset par_err", 80'(par_err), 80'(0));
        @(negedge clk) rst = 1'b0;

        // R4/R1/R2: all flags 1 after reset -> read-only words
        for (int a = 0; a < 6144; a++) begin
            if (a == 'h17FD) continue;
            fetch(a);
            chk("R4 rom after reset", cw, rom_fn(13'(a)));
        end
        chk("R8 no error on good words", 80'(par_err), 80'(0));

        // R6: hole above read-only depth
        for (int a = 6144; a < 'h2000; a++) begin
            fetch(a);
            chk("R6 hole zero", cw, '0);
        end

        // R10: load patch RAM and clear every third flag
        for (int i = 0; i < 1024; i++) load(2'd0, i, pat_fn(i));
        for (int a = 0; a < 'h2000; a += 3) load(2'd1, a, 80'(0));

        // R3/R4: mixed sweep with patching enabled
        for (int a = 0; a < 'h2000; a++) begin
            fetch(a);
            if (a % 3 == 0)     chk("R3 patched word", cw, pat_fn(a % 1024));
            else if (a < 6144)  chk("R4 unpatched rom", cw, rom_fn(13'(a)));
            else                chk("R6 unpatched hole", cw, '0);
        end
        chk("R3 patched bad word hidden", 80'(par_err), 80'(0));

        // R5: patch disabled forces read-only path
        patch_en = 1'b0;
        for (int a = 0; a < 6144; a++) begin
            if (a == 'h17FD) continue;
            fetch(a);
            chk("R5 patch off rom", cw, rom_fn(13'(a)));
        end
        patch_en = 1'b1;

        // R7: writable region
        for (int i = 0; i < 1024; i++) load(2'd2, 'h2000 + i, wcs_fn(i));
        for (int i = 0; i < 1024; i++) begin
            fetch('h2000 + i);
            chk("R7 wcs word", cw, wcs_fn(i));
        end
        fetch('h2400); chk("R7 above wcs", cw, '0);
        fetch('h3FFF); chk("R7 top address", cw, '0);

        // R10: select code 3 writes nothing
        load(2'd3, 3, ~pat_fn(3));
        fetch(3); chk("R10 code 3 ignored", cw, pat_fn(3));

        // R10/R2: same-cycle write returns old word, next fetch new
        old6 = pat_fn(6);
        @(negedge clk);
        uaddr = 14'd6;
        ld_valid = 1'b1; ld_sel = 2'd0; ld_addr = 14'd6; ld_data = wcs_fn(77);
        @(posedge clk);
        #1 ld_valid = 1'b0;
        chk("R10 read before write", cw, old6);
        fetch(6); chk("R10 new word visible", cw, wcs_fn(77));

        // R8/R9: bad read-only word reaches the checker
        patch_en = 1'b0;
        fetch('h17FD);
        chk("R8 bad word delivered", cw, rom_fn(13'h17FD));
        chk("R8 error raised", 80'(par_err), 80'(1));
        fetch(1); fetch(2);
        chk("R9 error sticky", 80'(par_err), 80'(1));
        patch_en = 1'b1;

        // R1: reset clears error and restores flags
        @(negedge clk) rst = 1'b1;
        @(posedge clk); #1;
        chk("R1 error cleared", 80'(par_err), 80'(0));
        @(negedge clk) rst = 1'b0;
        fetch(6);
        chk("R1 flags restored", cw, rom_fn(13'd6));

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule